// File: doc/BRIEF.md
# NAND Command and Address Decoder

This block is the device-side front end of an 8-bit NAND flash. It watches the write strobe and the two latch-enable pins. Each byte is captured on a rising write strobe while the chip is selected, and each is sorted into a command, an address byte or a data byte. From those bytes it builds a 21-bit byte address: 13 row bits over 8 column bits. It then tells a back end which operation to start through a single-cycle operation strobe. The strobe carries an operation code and an address.

Everything runs on one system clock. The asynchronous bus pins are registered once, and the rising write strobe is found by comparing the registered strobe with its delayed copy. The back end drives `busy` while an array operation runs. During that time only the status and reset commands pass. Any other command is dropped and raises a sticky error flag.

Top module: `nand_cmd_front`

## Requirements
- R1: A byte is taken only when a rising `we_n` is seen while `ce_n` is low; a byte written with `ce_n` high has no effect. The outputs for a byte appear during the clock cycle that follows the second rising clock edge after the edge that first registers `we_n` high. They last one cycle.
- R2: `cle`=1, `ale`=0 marks a command; `ale`=1, `cle`=0 marks an address; both low marks data; both high is ignored.
- R3: Command 00h or 50h, then address bytes column, low row, high row, gives one strobe. The code is 1 for 00h and 2 for 50h. The address is `{high[4:0], low, column}`, and the strobe fires on the third address byte.
- R4: Command 80h, then three address bytes in the same order, enters data loading. There each data byte is forwarded on `dat_valid`/`dat_byte`. Command 10h then gives code 3 with the loaded address. A 10h without a complete load gives nothing.
- R5: Command 60h takes two address bytes (low row, high row), then D0h gives code 4. The address is the row with its 4 low bits cleared, shifted over 8 zero column bits.
- R6: After the erase rows, any byte other than D0h aborts the erase, so a later D0h gives nothing. A command that aborts is still decoded itself.
- R7: 70h gives code 5 and 90h gives code 6, both with address 0. A 70h does not cancel a completed program load.
- R8: While `busy` is high, only 70h and FFh are decoded. Any other command is dropped, leaves the pending state unchanged and sets `err_flag`, which stays set until `rst`. Address and data bytes taken during `busy` are ignored.
- R9: FFh gives code 7 with address 0. It clears the pending command and the stored address, so a following 10h or D0h gives nothing.
- R10: Each accepted command restarts the address byte count. Address bytes beyond the expected count do not change the address and give no strobe.
- R11: Synchronous active-high `rst` clears all outputs and `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe; byte taken on its rise |
| cle | input | 1 | Marks the byte as a command |
| ale | input | 1 | Marks the byte as an address |
| busy | input | 1 | Back end is running an array operation |
| io | input | 8 | Byte bus |
| op_valid | output | 1 | One-cycle operation strobe |
| op_code | output | 3 | 1 read, 2 spare read, 3 program, 4 erase, 5 status, 6 ID, 7 reset |
| op_addr | output | 21 | Byte address for the operation |
| dat_valid | output | 1 | Program data byte strobe |
| dat_byte | output | 8 | Program data byte |
| err_flag | output | 1 | Sticky: command dropped while busy |

## Verification
Two events can fall on the same byte. A status or reset command that arrives while an erase waits for its confirm both cancels the erase and issues its own strobe. A command dropped during `busy` raises the error flag in the same cycle that it leaves a pending program load intact. The bench provokes each case with a behavioural model. It checks that the new strobe appears, that a later D0h stays silent, and that a later 10h still programs the saved address.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_READ       = 3'd1,
    OP_READ_SPARE = 3'd2,
    OP_PROG       = 3'd3,
    OP_ERASE      = 3'd4,
    OP_STATUS     = 3'd5,
    OP_ID         = 3'd6,
    OP_RESET      = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ADR,
    S_PG_ADR,
    S_PG_DAT,
    S_ER_ADR,
    S_ER_CNF
  } st_e;

  localparam logic [7:0] CMD_READ_A = 8'h00;
  localparam logic [7:0] CMD_READ_B = 8'h50;
  localparam logic [7:0] CMD_LOAD   = 8'h80;
  localparam logic [7:0] CMD_PROG   = 8'h10;
  localparam logic [7:0] CMD_ERASE  = 8'h60;
  localparam logic [7:0] CMD_GO     = 8'hD0;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_ID     = 8'h90;
  localparam logic [7:0] CMD_RESET  = 8'hFF;

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             busy,
  input  logic [BUS_W-1:0] io,
  output logic             cmd_vld,
  output logic             adr_vld,
  output logic             dat_vld,
  output logic             busy_o,
  output logic [BUS_W-1:0] byte_o
);

  logic             ce_s, we_s, we_d, cle_s, ale_s, busy_s;
  logic [BUS_W-1:0] io_s;
  logic             wr_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_s   <= 1'b1;
      we_s   <= 1'b1;
      we_d   <= 1'b1;
      cle_s  <= 1'b0;
      ale_s  <= 1'b0;
      busy_s <= 1'b0;
      io_s   <= '0;
    end else begin
      ce_s   <= ce_n;
      we_s   <= we_n;
      we_d   <= we_s;
      cle_s  <= cle;
      ale_s  <= ale;
      busy_s <= busy;
      io_s   <= io;
    end
  end

  assign wr_edge = we_s && !we_d && !ce_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_vld <= 1'b0;
      adr_vld <= 1'b0;
      dat_vld <= 1'b0;
      busy_o  <= 1'b0;
      byte_o  <= '0;
    end else begin
      cmd_vld <= wr_edge && cle_s && !ale_s;
      adr_vld <= wr_edge && ale_s && !cle_s;
      dat_vld <= wr_edge && !cle_s && !ale_s;
      busy_o  <= busy_s;
      byte_o  <= io_s;
    end
  end

  // R2: a captured byte has at most one class
  a_r2_one_class: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_vld, adr_vld, dat_vld}));

  // R1: a byte is only produced after a rising write strobe
  a_r1_needs_edge: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld || adr_vld || dat_vld) |-> $past(we_s && !we_d));

endmodule

// File: rtl/nand_addr_asm.sv
module nand_addr_asm #(
  parameter int BUS_W = 8,
  parameter int ROW_W = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_cnt,
  input  logic                      clr_all,
  input  logic                      take,
  input  logic [BUS_W-1:0]          din,
  input  logic [1:0]                need,
  input  logic                      row_only,
  output logic                      adr_last,
  output logic [ROW_W+BUS_W-1:0]    addr_next,
  output logic [ROW_W+BUS_W-1:0]    addr_q
);

  localparam int HI_W   = ROW_W - BUS_W;
  localparam int ADDR_W = ROW_W + BUS_W;

  logic [1:0]       cnt, idx;
  logic             cap;
  logic [BUS_W-1:0] col_q, rlo_q, col_n, rlo_n;
  logic [HI_W-1:0]  rhi_q, rhi_n;

  assign cap      = take && (cnt < need);
  assign idx      = row_only ? cnt + 2'd1 : cnt;
  assign adr_last = cap && ((cnt + 2'd1) == need);

  always_comb begin
    col_n = col_q;
    rlo_n = rlo_q;
    rhi_n = rhi_q;
    if (cap) begin
      case (idx)
        2'd0:    col_n = din;
        2'd1:    rlo_n = din;
        default: rhi_n = din[HI_W-1:0];
      endcase
    end
  end

  assign addr_next = {rhi_n, rlo_n, col_n};
  assign addr_q    = {rhi_q, rlo_q, col_q};

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      cnt   <= 2'd0;
      col_q <= '0;
      rlo_q <= '0;
      rhi_q <= '0;
    end else begin
      if (clr_cnt)  cnt <= 2'd0;
      else if (cap) cnt <= cnt + 2'd1;
      col_q <= col_n;
      rlo_q <= rlo_n;
      rhi_q <= rhi_n;
    end
  end

  // R10: surplus address bytes leave the stored address alone
  a_r10_surplus_ignored: assert property (@(posedge clk) disable iff (rst)
    (take && !cap) |=> $stable(addr_q));

  // R9: reset command wipes the stored address
  a_r9_addr_wiped: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (addr_q == {ADDR_W{1'b0}}));

endmodule

// File: rtl/nand_cmd_ctl.sv
module nand_cmd_ctl
  import nand_fe_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int ROW_W   = 13,
  parameter int BLK_LSB = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_vld,
  input  logic                   adr_vld,
  input  logic                   dat_vld,
  input  logic                   busy,
  input  logic [BUS_W-1:0]       din,
  input  logic                   adr_last,
  input  logic [ROW_W+BUS_W-1:0] addr_next,
  input  logic [ROW_W+BUS_W-1:0] addr_q,
  output logic                   clr_cnt,
  output logic                   clr_all,
  output logic                   take,
  output logic [1:0]             need,
  output logic                   row_only,
  output logic                   op_valid,
  output logic [2:0]             op_code,
  output logic [ROW_W+BUS_W-1:0] op_addr,
  output logic                   dat_valid,
  output logic [BUS_W-1:0]       dat_byte,
  output logic                   err_flag
);

  localparam int ADDR_W = ROW_W + BUS_W;
  localparam int LOW_Z  = BUS_W + BLK_LSB;

  st_e               st, st_n;
  logic              spare, spare_n;
  op_e               op_n;
  logic [ADDR_W-1:0] addr_n;
  logic              dv_n;
  logic              cmd_ok, cmd_drop, dat_ok;
  logic [ADDR_W-1:0] ers_addr;
  logic [7:0]        code;

  assign code     = 8'(din);
  assign cmd_ok   = cmd_vld && (!busy || code == CMD_STATUS || code == CMD_RESET);
  assign cmd_drop = cmd_vld && !cmd_ok;
  assign take     = adr_vld && !busy;
  assign dat_ok   = dat_vld && !busy;
  assign clr_cnt  = cmd_ok;
  assign clr_all  = cmd_ok && (code == CMD_RESET);
  assign row_only = (st == S_ER_ADR);
  assign need     = (st == S_RD_ADR || st == S_PG_ADR) ? 2'd3 :
                    (st == S_ER_ADR) ? 2'd2 : 2'd0;
  assign ers_addr = {addr_q[ADDR_W-1:LOW_Z], {LOW_Z{1'b0}}};

  always_comb begin
    st_n    = st;
    spare_n = spare;
    op_n    = OP_NONE;
    addr_n  = '0;
    dv_n    = 1'b0;
    if (cmd_ok) begin
      case (code)
        CMD_RESET: begin
          op_n = OP_RESET;
          st_n = S_IDLE;
        end
        CMD_READ_A: begin
          st_n    = S_RD_ADR;
          spare_n = 1'b0;
        end
        CMD_READ_B: begin
          st_n    = S_RD_ADR;
          spare_n = 1'b1;
        end
        CMD_LOAD:  st_n = S_PG_ADR;
        CMD_PROG: begin
          if (st == S_PG_DAT) begin
            op_n   = OP_PROG;
            addr_n = addr_q;
          end
          st_n = S_IDLE;
        end
        CMD_ERASE: st_n = S_ER_ADR;
        CMD_GO: begin
          if (st == S_ER_CNF) begin
            op_n   = OP_ERASE;
            addr_n = ers_addr;
          end
          st_n = S_IDLE;
        end
        CMD_STATUS: begin
          op_n = OP_STATUS;
          if (st == S_ER_CNF) st_n = S_IDLE;
        end
        CMD_ID: begin
          op_n = OP_ID;
          st_n = S_IDLE;
        end
        default: st_n = S_IDLE;
      endcase
    end else if (take) begin
      if (st == S_ER_CNF) begin
        st_n = S_IDLE;
      end else if (adr_last) begin
        case (st)
          S_RD_ADR: begin
            op_n   = spare ? OP_READ_SPARE : OP_READ;
            addr_n = addr_next;
            st_n   = S_IDLE;
          end
          S_PG_ADR: st_n = S_PG_DAT;
          S_ER_ADR: st_n = S_ER_CNF;
          default:  st_n = st;
        endcase
      end
    end else if (dat_ok) begin
      if (st == S_ER_CNF)      st_n = S_IDLE;
      else if (st == S_PG_DAT) dv_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      spare     <= 1'b0;
      op_valid  <= 1'b0;
      op_code   <= 3'd0;
      op_addr   <= '0;
      dat_valid <= 1'b0;
      dat_byte  <= '0;
      err_flag  <= 1'b0;
    end else begin
      st        <= st_n;
      spare     <= spare_n;
      op_valid  <= (op_n != OP_NONE);
      op_code   <= op_n;
      op_addr   <= addr_n;
      dat_valid <= dv_n;
      dat_byte  <= dv_n ? din : '0;
      err_flag  <= err_flag || cmd_drop;
    end
  end

  // R8: a command refused during busy raises the flag and issues nothing
  a_r8_drop_flags: assert property (@(posedge clk) disable iff (rst)
    cmd_drop |=> (err_flag && !op_valid));

  // R8: the error flag holds until reset
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R5: an erase strobe always follows a confirm command byte
  a_r5_erase_after_go: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ERASE) |-> $past(cmd_vld && code == CMD_GO && !busy));

  // R4: forwarded data always comes from a data byte outside busy
  a_r4_data_source: assert property (@(posedge clk) disable iff (rst)
    dat_valid |-> $past(dat_vld && !busy));

  // R3: a strobe never carries the empty code
  a_r3_code_nonzero: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_code != 3'd0));

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front #(
  parameter int BUS_W   = 8,
  parameter int ROW_W   = 13,
  parameter int BLK_LSB = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce_n,
  input  logic                   we_n,
  input  logic                   cle,
  input  logic                   ale,
  input  logic                   busy,
  input  logic [BUS_W-1:0]       io,
  output logic                   op_valid,
  output logic [2:0]             op_code,
  output logic [ROW_W+BUS_W-1:0] op_addr,
  output logic                   dat_valid,
  output logic [BUS_W-1:0]       dat_byte,
  output logic                   err_flag
);

  localparam int ADDR_W = ROW_W + BUS_W;

  logic              cmd_vld, adr_vld, dat_vld, busy_q;
  logic [BUS_W-1:0]  byte_q;
  logic              clr_cnt, clr_all, take, row_only, adr_last;
  logic [1:0]        need;
  logic [ADDR_W-1:0] addr_next, addr_q;

  nand_bus_sampler #(.BUS_W(BUS_W)) u_smp (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
    .busy(busy), .io(io), .cmd_vld(cmd_vld), .adr_vld(adr_vld),
    .dat_vld(dat_vld), .busy_o(busy_q), .byte_o(byte_q)
  );

  nand_addr_asm #(.BUS_W(BUS_W), .ROW_W(ROW_W)) u_adr (
    .clk(clk), .rst(rst), .clr_cnt(clr_cnt), .clr_all(clr_all), .take(take),
    .din(byte_q), .need(need), .row_only(row_only), .adr_last(adr_last),
    .addr_next(addr_next), .addr_q(addr_q)
  );

  nand_cmd_ctl #(.BUS_W(BUS_W), .ROW_W(ROW_W), .BLK_LSB(BLK_LSB)) u_ctl (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .adr_vld(adr_vld),
    .dat_vld(dat_vld), .busy(busy_q), .din(byte_q), .adr_last(adr_last),
    .addr_next(addr_next), .addr_q(addr_q), .clr_cnt(clr_cnt),
    .clr_all(clr_all), .take(take), .need(need), .row_only(row_only),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .err_flag(err_flag)
  );

endmodule

// File: tb/sim_nand_cmd_front.sv
module sim_nand_cmd_front;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0, busy = 1'b0;
  logic [7:0]  io = 8'h00;
  logic        op_valid, dat_valid, err_flag;
  logic [2:0]  op_code;
  logic [20:0] op_addr;
  logic [7:0]  dat_byte;

  nand_cmd_front u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
    .busy(busy), .io(io), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .dat_valid(dat_valid), .dat_byte(dat_byte),
    .err_flag(err_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    cyc;
    int    code;
    int    addr;
    bit    dv;
    int    db;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    checks = 0, errors = 0;
  int    err_cyc = -1;
  bit    run = 1'b0, done = 1'b0;
  string cur_req = "R11";

  // model state: 0 idle,1 read addr,2 prog addr,3 prog data,4 erase addr,5 erase confirm
  int m_st = 0, m_cnt = 0, m_col = 0, m_rlo = 0, m_rhi = 0;
  bit m_spare = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int code, int addr, bit dv, int db, string tag);
    exp_t e;
    e.cyc = cyc + 3; e.code = code; e.addr = addr; e.dv = dv; e.db = db; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic model(bit c, bit a, bit ce_hi, bit bz, int b);
    int need, idx;
    if (ce_hi || (c && a)) return;
    if (c) begin
      if (bz && b != 8'h70 && b != 8'hFF) begin
        if (err_cyc < 0) err_cyc = cyc + 3;
        return;
      end
      m_cnt = 0;
      case (b)
        8'hFF: begin push(7, 0, 0, 0, "R9"); m_st = 0; m_col = 0; m_rlo = 0; m_rhi = 0; end
        8'h00: begin m_st = 1; m_spare = 0; end
        8'h50: begin m_st = 1; m_spare = 1; end
        8'h80: m_st = 2;
        8'h10: begin
          if (m_st == 3) push(3, (m_rhi << 16) | (m_rlo << 8) | m_col, 0, 0, "R4");
          m_st = 0;
        end
        8'h60: m_st = 4;
        8'hD0: begin
          if (m_st == 5) push(4, (((m_rhi << 8) | m_rlo) & ~15) << 8, 0, 0, "R5");
          m_st = 0;
        end
        8'h70: begin push(5, 0, 0, 0, "R7"); if (m_st == 5) m_st = 0; end
        8'h90: begin push(6, 0, 0, 0, "R7"); m_st = 0; end
        default: m_st = 0;
      endcase
    end else if (a) begin
      if (bz) return;
      if (m_st == 5) begin m_st = 0; return; end
      need = (m_st == 1 || m_st == 2) ? 3 : (m_st == 4) ? 2 : 0;
      if (m_cnt >= need) return;
      idx = (m_st == 4) ? m_cnt + 1 : m_cnt;
      if (idx == 0) m_col = b;
      else if (idx == 1) m_rlo = b;
      else m_rhi = b & 31;
      m_cnt++;
      if (m_cnt == need) begin
        if (m_st == 1) begin
          push(m_spare ? 2 : 1, (m_rhi << 16) | (m_rlo << 8) | m_col, 0, 0, "R3");
          m_st = 0;
        end else if (m_st == 2) m_st = 3;
        else m_st = 5;
      end
    end else begin
      if (bz) return;
      if (m_st == 5) m_st = 0;
      else if (m_st == 3) push(0, 0, 1, b, "R4");
    end
  endtask

  task automatic wr(bit c, bit a, int b, bit ce_hi = 1'b0);
    @(negedge clk);
    ce_n = ce_hi; cle = c; ale = a; io = 8'(b); we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    model(c, a, ce_hi, busy, b);
    @(negedge clk);
    ce_n = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(int b);  wr(1'b1, 1'b0, b); endtask
  task automatic adr(int b);  wr(1'b0, 1'b1, b); endtask
  task automatic dat(int b);  wr(1'b0, 1'b0, b); endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0; rst = 1'b1;
    q.delete(); err_cyc = -1;
    m_st = 0; m_cnt = 0; m_col = 0; m_rlo = 0; m_rhi = 0; m_spare = 0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state at the ports
    checks++;
    if (op_valid !== 1'b0 || dat_valid !== 1'b0 || err_flag !== 1'b0 || op_code !== 3'd0) begin
      errors++;
      $display("FAIL R11 reset state: op_valid=%0b dat_valid=%0b err=%0b code=%0d expected 0 0 0 0",
               op_valid, dat_valid, err_flag, op_code);
    end
    run = 1'b1;
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (run && !rst) begin
      int    e_code, e_addr, e_db;
      bit    e_v, e_dv, e_err;
      string tag;
      e_v = 0; e_code = 0; e_addr = 0; e_dv = 0; e_db = 0; tag = cur_req;
      if (q.size() > 0 && q[0].cyc == cyc) begin
        e_v  = (q[0].code != 0);
        e_code = q[0].code; e_addr = q[0].addr;
        e_dv = q[0].dv; e_db = q[0].db; tag = q[0].tag;
        void'(q.pop_front());
      end
      e_err = (err_cyc >= 0 && cyc >= err_cyc);
      checks++;
      if (op_valid !== e_v || (e_v && (int'(op_code) != e_code || int'(op_addr) != e_addr)) ||
          dat_valid !== e_dv || (e_dv && int'(dat_byte) != e_db) || err_flag !== e_err) begin
        errors++;
        $display("FAIL %s cyc %0d: got v=%0b code=%0d addr=%h dv=%0b db=%h err=%0b expected v=%0b code=%0d addr=%h dv=%0b db=%h err=%0b",
                 tag, cyc, op_valid, op_code, op_addr, dat_valid, dat_byte, err_flag,
                 e_v, e_code, e_addr[20:0], e_dv, e_db[7:0], e_err);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: expected end of test");
    finish_run();
  end

  initial begin
    do_reset();

    // R3: main and spare reads, R10 surplus byte
    cur_req = "R3";
    cmd(8'h00); adr(8'h12); adr(8'h34); adr(8'h1F);
    cur_req = "R10";
    adr(8'h66);
    cur_req = "R3";
    cmd(8'h50); adr(8'h05); adr(8'hAB); adr(8'h3C);
    idle(4);

    // R1: chip deselected; R2: both latches high
    cur_req = "R1";
    wr(1'b1, 1'b0, 8'h70, 1'b1);
    cur_req = "R2";
    wr(1'b1, 1'b1, 8'h70);
    dat(8'h44);
    idle(4);

    // R4: program with data, surplus address ignored (R10)
    cur_req = "R4";
    cmd(8'h80); adr(8'h00); adr(8'h10); adr(8'h02);
    dat(8'hA5); dat(8'h5A);
    cur_req = "R10";
    adr(8'h77);
    cur_req = "R4";
    cmd(8'h10);
    cmd(8'h10);
    cmd(8'h80); adr(8'h01); cmd(8'h10);
    idle(4);

    // R5: erase with confirm
    cur_req = "R5";
    cmd(8'h60); adr(8'h37); adr(8'h0A); cmd(8'hD0);
    cmd(8'hD0);
    idle(4);

    // R6: aborts by data, by status command (decoded too), by address
    cur_req = "R6";
    cmd(8'h60); adr(8'h11); adr(8'h02); dat(8'h99); cmd(8'hD0);
    cmd(8'h60); adr(8'h11); adr(8'h02); cmd(8'h70); cmd(8'hD0);
    cmd(8'h60); adr(8'h11); adr(8'h02); adr(8'h55); cmd(8'hD0);
    idle(4);

    // R7: ID, status keeps a program load
    cur_req = "R7";
    cmd(8'h90);
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03);
    cmd(8'h70); cmd(8'h10);
    idle(4);

    // R8: busy filtering
    cur_req = "R8";
    cmd(8'h80); adr(8'h0C); adr(8'h0B); adr(8'h0A);
    @(negedge clk); busy = 1'b1;
    cmd(8'h00);
    cmd(8'h10);
    adr(8'hEE); dat(8'hEE);
    cmd(8'h70);
    @(negedge clk); busy = 1'b0;
    cmd(8'h10);
    cmd(8'h60); adr(8'h20); adr(8'h01);
    @(negedge clk); busy = 1'b1;
    cmd(8'hD0);
    @(negedge clk); busy = 1'b0;
    cmd(8'hD0);
    @(negedge clk); busy = 1'b1;
    cmd(8'hFF);
    @(negedge clk); busy = 1'b0;
    idle(4);

    // R9: reset command clears pending operations
    cur_req = "R9";
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'hFF); cmd(8'h10);
    cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'hFF); cmd(8'hD0);
    idle(4);

    // R10: new command restarts the byte count
    cur_req = "R10";
    cmd(8'h00); adr(8'h01); adr(8'h02); cmd(8'h00);
    adr(8'h04); adr(8'h05); adr(8'h06);
    idle(4);

    // R11: mid-run reset clears the sticky flag
    cur_req = "R11";
    do_reset();
    cmd(8'h70);
    idle(6);

    finish_run();
  end

endmodule